// File: doc/BRIEF.md
# Dual-mode base address register decoder

This block holds the programmable base address of a bus target and decides, for every incoming bus address, whether that target is selected and which of its internal registers is addressed. The base register lives at one offset of the configuration space. A host reaches it through byte-enabled configuration reads and writes. An internal core may also write it while the block is in self-configuration mode.

The upper half of the register does two jobs. In PCI-style memory mode the whole upper half is a 64 KB-aligned memory base. In the narrow parallel-bus mode only its low byte (register bits 23:16) is used, as an 8-bit base that selects a window of eight locations. The lower half of the register is hardwired to zero. A 3-bit mode input selects the personality and gates host access.

Top module: `dual_bar_decoder`

## Requirements
- R1: After reset the base field (register bits 31:16) is zero, and a permitted configuration read returns 0x00000000.
- R2: A host write takes effect on the next clock edge. It needs mode 1 (PCI), `cfg_sel_i`, `cfg_we_i` and `cfg_addr_i` = 0x10. Byte lane 3 (bits 31:24) is written only when `cfg_be_i[3]` is set, and lane 2 (bits 23:16) only when `cfg_be_i[2]` is set. A lane that is not enabled keeps its contents.
- R3: Register bits 15:0 always read as zero. Writes to lanes 1 and 0 have no effect.
- R4: When the mode is not 1, or the offset is not 0x10, or `cfg_sel_i` is low, host writes leave the register unchanged and `cfg_rdata_o` is zero.
- R5: In mode 5 (self-configuration), `core_we_i` writes `core_wdata_i` into the register on the next edge, lane by lane under `core_be_i`, using the same lanes as R2. In every other mode the core write is ignored.
- R6: In modes 1 and 5, `tgt_sel_o` is high exactly when `bus_addr_i[31:16]` equals the base, and `reg_idx_o` then equals `bus_addr_i[11:0]`.
- R7: In mode 0 (narrow bus), `tgt_sel_o` is high exactly when `bus_addr_i[10:3]` equals register bits 23:16, and `reg_idx_o` then equals `bus_addr_i[2:0]` zero-extended. All other register and address bits are ignored.
- R8: In modes 2, 3, 4, 6 and 7, `tgt_sel_o` is low. Whenever `tgt_sel_o` is low, `reg_idx_o` is zero.
- R9: A permitted configuration read (mode 1, `cfg_sel_i`, `cfg_re_i`, offset 0x10) returns the register in the same cycle. If a write is presented in that same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Operating mode: 0 narrow bus, 1 PCI, 5 self-configuration |
| cfg_sel_i | input | 1 | A configuration cycle is in progress |
| cfg_addr_i | input | 8 | Configuration byte offset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_re_i | input | 1 | Configuration read strobe |
| cfg_be_i | input | 4 | Configuration byte enables |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration read data (zero when the read is not permitted) |
| core_we_i | input | 1 | Internal self-configuration write strobe |
| core_be_i | input | 4 | Internal write byte enables |
| core_wdata_i | input | 32 | Internal write data |
| bus_addr_i | input | 32 | Incoming bus address to decode |
| tgt_sel_o | output | 1 | Target selected |
| reg_idx_o | output | 12 | Internal register index |

## Verification
A configuration read and a configuration write can fall in the same cycle. The read path is combinational while the write lands on the following edge. The bench provokes this by presenting a full-lane write together with a read. It expects the old register value in that cycle and the new value on the next probe. Address decoding also runs in the cycle right after a write, so the bench decodes against the new base immediately to confirm that the match logic follows the register without extra delay.

// File: rtl/dual_bar_decoder_pkg.sv
package dual_bar_decoder_pkg;
    localparam logic [2:0] MODE_NARROW = 3'd0;
    localparam logic [2:0] MODE_PCI    = 3'd1;
    localparam logic [2:0] MODE_SELF   = 3'd5;

    typedef struct packed {
        logic       en;
        logic [1:0] be;
        logic [15:0] data;
    } lane_wr_t;
endpackage

// File: rtl/dbd_access.sv
module dbd_access
    import dual_bar_decoder_pkg::*;
#(
    parameter int CFG_AW  = 8,
    parameter logic [CFG_AW-1:0] BAR_OFS = 8'h10,
    parameter int BASE_LSB = 16,
    parameter int DATA_W  = 32
) (
    input  logic [2:0]        mode_i,
    input  logic              cfg_sel_i,
    input  logic [CFG_AW-1:0] cfg_addr_i,
    input  logic              cfg_we_i,
    input  logic              cfg_re_i,
    input  logic [DATA_W/8-1:0] cfg_be_i,
    input  logic [DATA_W-1:0] cfg_wdata_i,
    input  logic              core_we_i,
    input  logic [DATA_W/8-1:0] core_be_i,
    input  logic [DATA_W-1:0] core_wdata_i,
    output logic              host_rd_o,
    output lane_wr_t          wr_o
);
    localparam int LO_LANES = BASE_LSB / 8;
    localparam int NB       = DATA_W / 8;

    logic host_ok;
    logic core_ok;

    always_comb begin
        host_ok   = (mode_i == MODE_PCI) && cfg_sel_i && (cfg_addr_i == BAR_OFS);
        core_ok   = (mode_i == MODE_SELF) && core_we_i;
        host_rd_o = host_ok && cfg_re_i;
        wr_o      = '0;
        // internal path has priority over the host path
        if (core_ok) begin
            wr_o.en   = 1'b1;
            wr_o.be   = core_be_i[NB-1:LO_LANES];
            wr_o.data = core_wdata_i[DATA_W-1:BASE_LSB];
        end else if (host_ok && cfg_we_i) begin
            wr_o.en   = 1'b1;
            wr_o.be   = cfg_be_i[NB-1:LO_LANES];
            wr_o.data = cfg_wdata_i[DATA_W-1:BASE_LSB];
        end
    end
endmodule

// File: rtl/dbd_store.sv
module dbd_store
    import dual_bar_decoder_pkg::*;
#(
    parameter int BASE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  lane_wr_t          wr_i,
    output logic [BASE_W-1:0] base_o
);
    localparam int LANES = BASE_W / 8;

    typedef struct packed {
        logic [BASE_W-1:0] base;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i.en) begin
            for (int i = 0; i < LANES; i++) begin
                if (wr_i.be[i]) st_d.base[i*8 +: 8] = wr_i.data[i*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign base_o = st_q.base;
endmodule

// File: rtl/dbd_match.sv
module dbd_match
    import dual_bar_decoder_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int BASE_W  = 16,
    parameter int IDX_W   = 12,
    parameter int NB_LO   = 3,
    parameter int NB_W    = 8
) (
    input  logic [2:0]        mode_i,
    input  logic [BASE_W-1:0] base_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              sel_o,
    output logic [IDX_W-1:0]  idx_o
);
    localparam int BASE_LSB = ADDR_W - BASE_W;

    logic mem_hit;
    logic nb_hit;

    always_comb begin
        mem_hit = (addr_i[ADDR_W-1:BASE_LSB] == base_i);
        nb_hit  = (addr_i[NB_LO+NB_W-1:NB_LO] == base_i[NB_W-1:0]);
        sel_o   = 1'b0;
        idx_o   = '0;
        case (mode_i)
            MODE_PCI, MODE_SELF: begin
                sel_o = mem_hit;
                if (mem_hit) idx_o = addr_i[IDX_W-1:0];
            end
            MODE_NARROW: begin
                sel_o = nb_hit;
                if (nb_hit) idx_o = {{(IDX_W-NB_LO){1'b0}}, addr_i[NB_LO-1:0]};
            end
            default: begin
                sel_o = 1'b0;
                idx_o = '0;
            end
        endcase
    end
endmodule

// File: rtl/dual_bar_decoder.sv
module dual_bar_decoder
    import dual_bar_decoder_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int CFG_AW   = 8,
    parameter logic [CFG_AW-1:0] BAR_OFS = 8'h10,
    parameter int BASE_LSB = 16,
    parameter int IDX_W    = 12,
    parameter int NB_LO    = 3,
    parameter int NB_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_i,
    input  logic              cfg_sel_i,
    input  logic [CFG_AW-1:0] cfg_addr_i,
    input  logic              cfg_we_i,
    input  logic              cfg_re_i,
    input  logic [ADDR_W/8-1:0] cfg_be_i,
    input  logic [ADDR_W-1:0] cfg_wdata_i,
    output logic [ADDR_W-1:0] cfg_rdata_o,
    input  logic              core_we_i,
    input  logic [ADDR_W/8-1:0] core_be_i,
    input  logic [ADDR_W-1:0] core_wdata_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    output logic              tgt_sel_o,
    output logic [IDX_W-1:0]  reg_idx_o
);
    localparam int BASE_W = ADDR_W - BASE_LSB;

    lane_wr_t          wr;
    logic              host_rd;
    logic [BASE_W-1:0] base_q;

    dbd_access #(.CFG_AW(CFG_AW), .BAR_OFS(BAR_OFS), .BASE_LSB(BASE_LSB), .DATA_W(ADDR_W)) u_access (
        .mode_i(mode_i), .cfg_sel_i(cfg_sel_i), .cfg_addr_i(cfg_addr_i),
        .cfg_we_i(cfg_we_i), .cfg_re_i(cfg_re_i), .cfg_be_i(cfg_be_i),
        .cfg_wdata_i(cfg_wdata_i), .core_we_i(core_we_i), .core_be_i(core_be_i),
        .core_wdata_i(core_wdata_i), .host_rd_o(host_rd), .wr_o(wr)
    );

    dbd_store #(.BASE_W(BASE_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_i(wr), .base_o(base_q)
    );

    dbd_match #(.ADDR_W(ADDR_W), .BASE_W(BASE_W), .IDX_W(IDX_W), .NB_LO(NB_LO), .NB_W(NB_W)) u_match (
        .mode_i(mode_i), .base_i(base_q), .addr_i(bus_addr_i),
        .sel_o(tgt_sel_o), .idx_o(reg_idx_o)
    );

    assign cfg_rdata_o = host_rd ? {base_q, {BASE_LSB{1'b0}}} : '0;
endmodule

// File: rtl/dual_bar_decoder_chk.sv
module dual_bar_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  mode_i,
    input logic        cfg_sel_i,
    input logic [7:0]  cfg_addr_i,
    input logic        cfg_we_i,
    input logic        cfg_re_i,
    input logic [3:0]  cfg_be_i,
    input logic        core_we_i,
    input logic [3:0]  core_be_i,
    input logic [31:0] bus_addr_i,
    input logic [31:0] cfg_rdata_o,
    input logic        tgt_sel_o,
    input logic [11:0] reg_idx_o,
    input logic [15:0] base
);
    logic host_acc;
    logic any_wr;
    assign host_acc = (mode_i == 3'd1) && cfg_sel_i && (cfg_addr_i == 8'h10);
    assign any_wr   = (host_acc && cfg_we_i && (cfg_be_i[3:2] != 2'b00)) ||
                      ((mode_i == 3'd5) && core_we_i && (core_be_i[3:2] != 2'b00));

    // R1: reset clears the base
    p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> base == 16'h0);
    // R2, R5: no enabled write, no change
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n) !any_wr |=> $stable(base));
    // R3: low half reads zero
    p_low_zero_r3: assert property (@(posedge clk) disable iff (!rst_n) cfg_rdata_o[15:0] == 16'h0);
    // R4: no host read outside PCI mode
    p_no_host_r4: assert property (@(posedge clk) disable iff (!rst_n) (mode_i != 3'd1) |-> cfg_rdata_o == 32'h0);
    // R6: memory-mode select implies match
    p_mem_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_i == 3'd1) && tgt_sel_o) |-> (bus_addr_i[31:16] == base && reg_idx_o == bus_addr_i[11:0]));
    // R7: narrow-mode select implies match
    p_nb_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_i == 3'd0) && tgt_sel_o) |-> (bus_addr_i[10:3] == base[7:0] && reg_idx_o == {9'd0, bus_addr_i[2:0]}));
    // R8: idle decoder
    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n) !tgt_sel_o |-> reg_idx_o == 12'h0);
    // R9: permitted read returns current register
    p_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_acc && cfg_re_i) |-> cfg_rdata_o == {base, 16'h0});
endmodule

bind dual_bar_decoder dual_bar_decoder_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .cfg_sel_i(cfg_sel_i),
    .cfg_addr_i(cfg_addr_i), .cfg_we_i(cfg_we_i), .cfg_re_i(cfg_re_i),
    .cfg_be_i(cfg_be_i), .core_we_i(core_we_i), .core_be_i(core_be_i),
    .bus_addr_i(bus_addr_i), .cfg_rdata_o(cfg_rdata_o), .tgt_sel_o(tgt_sel_o),
    .reg_idx_o(reg_idx_o), .base(base_q)
);

// File: tb/dual_bar_decoder_bench.sv
module dual_bar_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode_i = 3'd1;
    logic        cfg_sel_i = 1'b0;
    logic [7:0]  cfg_addr_i = 8'h0;
    logic        cfg_we_i = 1'b0;
    logic        cfg_re_i = 1'b0;
    logic [3:0]  cfg_be_i = 4'h0;
    logic [31:0] cfg_wdata_i = 32'h0;
    logic [31:0] cfg_rdata_o;
    logic        core_we_i = 1'b0;
    logic [3:0]  core_be_i = 4'h0;
    logic [31:0] core_wdata_i = 32'h0;
    logic [31:0] bus_addr_i = 32'h0;
    logic        tgt_sel_o;
    logic [11:0] reg_idx_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        string       req;
        logic [31:0] rd;
        logic        sel;
        logic [11:0] idx;
    } item_t;
    item_t sb[$];
    event  chk_ev;

    always #10 clk = ~clk;

    dual_bar_decoder u_dual_bar_decoder (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .cfg_sel_i(cfg_sel_i),
        .cfg_addr_i(cfg_addr_i), .cfg_we_i(cfg_we_i), .cfg_re_i(cfg_re_i),
        .cfg_be_i(cfg_be_i), .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o),
        .core_we_i(core_we_i), .core_be_i(core_be_i), .core_wdata_i(core_wdata_i),
        .bus_addr_i(bus_addr_i), .tgt_sel_o(tgt_sel_o), .reg_idx_o(reg_idx_o)
    );

    // monitor: pops expectations and compares them with the outputs
    initial begin
        forever begin
            @(chk_ev);
            while (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if (cfg_rdata_o !== it.rd || tgt_sel_o !== it.sel || reg_idx_o !== it.idx) begin
                    errors++;
                    $display("FAIL %s: rdata=%h sel=%b idx=%h expected rdata=%h sel=%b idx=%h",
                             it.req, cfg_rdata_o, tgt_sel_o, reg_idx_o, it.rd, it.sel, it.idx);
                end
            end
        end
    end

    task automatic idle();
        cfg_sel_i = 0; cfg_we_i = 0; cfg_re_i = 0; cfg_be_i = 0;
        cfg_addr_i = 8'h0; cfg_wdata_i = 0;
        core_we_i = 0; core_be_i = 0; core_wdata_i = 0;
    endtask

    task automatic host_wr(input logic [2:0] m, input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        idle();
        mode_i = m; cfg_sel_i = 1; cfg_we_i = 1; cfg_addr_i = a; cfg_be_i = be; cfg_wdata_i = d;
        @(negedge clk);
        idle();
    endtask

    task automatic core_wr(input logic [2:0] m, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        idle();
        mode_i = m; core_we_i = 1; core_be_i = be; core_wdata_i = d;
        @(negedge clk);
        idle();
    endtask

    // driver: applies a read/decode probe and queues the expected outputs
    task automatic probe(input string r, input logic [2:0] m, input logic [7:0] a, input logic [31:0] ba,
                         input logic [31:0] e_rd, input logic e_sel, input logic [11:0] e_idx);
        item_t it;
        @(negedge clk);
        idle();
        mode_i = m; cfg_sel_i = 1; cfg_re_i = 1; cfg_addr_i = a; bus_addr_i = ba;
        #2;
        it.req = r; it.rd = e_rd; it.sel = e_sel; it.idx = e_idx;
        sb.push_back(it);
        ->chk_ev;
        #1;
    endtask

    initial begin
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        probe("R1 reset value", 3'd1, 8'h10, 32'h0000_0123, 32'h0, 1'b1, 12'h123);

        host_wr(3'd1, 8'h10, 4'b1111, 32'hABCD_FFFF);
        probe("R2 full write", 3'd1, 8'h10, 32'h0, 32'hABCD_0000, 1'b0, 12'h0);
        host_wr(3'd1, 8'h10, 4'b0100, 32'h1234_5678);
        probe("R2 lane2 only", 3'd1, 8'h10, 32'h0, 32'hAB34_0000, 1'b0, 12'h0);
        host_wr(3'd1, 8'h10, 4'b1000, 32'h9900_0000);
        probe("R2 lane3 only", 3'd1, 8'h10, 32'h0, 32'h9934_0000, 1'b0, 12'h0);
        host_wr(3'd1, 8'h10, 4'b0011, 32'hFFFF_FFFF);
        probe("R3 low lanes ignored", 3'd1, 8'h10, 32'h0, 32'h9934_0000, 1'b0, 12'h0);

        host_wr(3'd0, 8'h10, 4'b1111, 32'h1111_0000);
        probe("R4 mode0 write blocked", 3'd1, 8'h10, 32'h0, 32'h9934_0000, 1'b0, 12'h0);
        host_wr(3'd1, 8'h14, 4'b1111, 32'h2222_0000);
        probe("R4 wrong offset write", 3'd1, 8'h10, 32'h0, 32'h9934_0000, 1'b0, 12'h0);
        probe("R4 wrong offset read", 3'd1, 8'h14, 32'h0, 32'h0, 1'b0, 12'h0);
        probe("R4 mode5 host read", 3'd5, 8'h10, 32'h0, 32'h0, 1'b0, 12'h0);

        core_wr(3'd5, 4'b1111, 32'h5566_7788);
        probe("R5 core write mode5", 3'd1, 8'h10, 32'h0, 32'h5566_0000, 1'b0, 12'h0);
        core_wr(3'd1, 4'b1111, 32'hDEAD_0000);
        probe("R5 core write ignored", 3'd1, 8'h10, 32'h0, 32'h5566_0000, 1'b0, 12'h0);

        probe("R6 mem hit", 3'd1, 8'h00, 32'h5566_0ABC, 32'h0, 1'b1, 12'hABC);
        probe("R6 mem miss", 3'd1, 8'h00, 32'h5567_0ABC, 32'h0, 1'b0, 12'h0);
        probe("R6 self mode hit", 3'd5, 8'h00, 32'h5566_F123, 32'h0, 1'b1, 12'h123);

        probe("R7 narrow hit", 3'd0, 8'h00, 32'hFFFF_F800 | 32'h0000_0335, 32'h0, 1'b1, 12'h005);
        probe("R7 narrow miss", 3'd0, 8'h00, 32'h0000_032D, 32'h0, 1'b0, 12'h0);

        probe("R8 mode3 off", 3'd3, 8'h00, 32'h5566_0ABC, 32'h0, 1'b0, 12'h0);
        probe("R8 mode7 off", 3'd7, 8'h00, 32'h0000_0335, 32'h0, 1'b0, 12'h0);

        // R9: read and write in the same cycle
        begin
            item_t it;
            @(negedge clk);
            idle();
            mode_i = 3'd1; cfg_sel_i = 1; cfg_re_i = 1; cfg_we_i = 1;
            cfg_addr_i = 8'h10; cfg_be_i = 4'b1111; cfg_wdata_i = 32'h7777_0000;
            bus_addr_i = 32'h0;
            #2;
            it.req = "R9 read old during write"; it.rd = 32'h5566_0000; it.sel = 1'b0; it.idx = 12'h0;
            sb.push_back(it);
            ->chk_ev;
            #1;
        end
        probe("R9 read new after write", 3'd1, 8'h10, 32'h7777_0042, 32'h7777_0000, 1'b1, 12'h042);

        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule